// File: doc/BRIEF.md
# Accelerator Control Register Interface

This block is an AXI4-Lite slave that sits between a host processor and a streaming compute core. The host uses it to launch the core, to watch its progress and to hand it scalar arguments. Toward the core it drives a start level and a flat vector of wide arguments. From the core it takes a done pulse, a ready pulse and an idle level. It also drives one level-sensitive interrupt line.

Each argument is wider than the bus, so it is split across consecutive 32-bit words, least significant word first. A reserved word follows every argument. The status bits have different side effects. Start clears when the core accepts it. Done stays set until the host reads the control word. Interrupt status bits flip when the host writes a one to them. An auto-restart mode launches the core again after every completion.

Word map (byte offsets): 0x00 control, 0x04 global interrupt enable, 0x08 per-source enables, 0x0c interrupt status. Argument `a`, word `w` sits at 0x10 + 12·a + 4·w. That gives 0x10/0x14 for the first argument and 0x1c/0x20 for the second, with 0x18 and 0x24 reserved.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset, every register, `core_start`, `irq`, `s_bvalid` and `s_rvalid` are 0, and `s_awready`, `s_wready` and `s_arready` are 1.
- R2: The write address and write data may arrive in either order or together. Each is held until both are present. The register write and `s_bvalid` take effect on the clock edge after the later of the two is accepted. `s_bresp` is 2'b00 (OKAY), and `s_bvalid` stays high until `s_bready`.
- R3: A write changes only the bytes whose `s_wstrb` bit is 1. Bit `b` of the strobe covers data bits 8b+7..8b. The control and enable fields live in byte 0 and change only when strobe bit 0 is set.
- R4: Writing 1 to control bit 0 sets `core_start`. Writing 0 there has no effect. `core_start` falls on the edge after a cycle in which it is high and `core_ready` is high.
- R5: Control bit 1 (done) is set by a `core_done` pulse and stays set. A read of offset 0x00 returns it and then clears it. A done pulse in the same cycle as that read leaves it set.
- R6: A control read returns `core_idle` in bit 2 and `core_ready` in bit 3, as sampled in the cycle the read is accepted. Bit 7 is auto-restart (read/write). All other control bits read 0.
- R7: While auto-restart is 1, a `core_done` pulse sets `core_start` again on the next edge.
- R8: Offset 0x04 bit 0 is the global interrupt enable. Offset 0x08 bit 0 enables the done source and bit 1 enables the ready source. All three are read/write.
- R9: Interrupt status at 0x0c: bit 0 is set by `core_done` when the done source is enabled, and bit 1 by `core_ready` when the ready source is enabled. Writing 1 to a bit toggles it. In the same cycle, a set wins over a toggle.
- R10: `irq` equals global enable AND ((done enable AND status bit 0) OR (ready enable AND status bit 1)), one edge after those registers take their values.
- R11: Argument `a` word `w` is read/write at byte offset 0x10 + 12·a + 4·w and drives `core_args[64a + 32w +: 32]`.
- R12: Reserved offsets (0x18, 0x24 and every unmapped word) read as 0, writes to them change nothing, and `s_rresp` is always 2'b00.
- R13: `s_rvalid` rises on the edge that accepts the read address. While `s_rvalid` is high, `s_arready` is low and `s_rdata` is stable until `s_rready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Start level to the compute core |
| core_done | input | 1 | Completion pulse from the core |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core accepts start / ready pulse |
| core_args | output | NUM_ARGS*ARG_W | Argument vector to the core |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: two 64-bit arguments on a 32-bit bus and a 6-bit address. At that size every argument word, both reserved gaps (0x18, 0x24) and the unmapped words above 0x24 are reachable, so the stride rule and the reserved-word decode are both exercised. A behavioural model tracks the channel handshakes and the register state, and is compared against the ports on every cycle. Directed sequences cover the three write orderings, partial strobes, a done pulse that collides with a control read, toggle writes to the interrupt status, auto-restart relaunch, and a read held while `s_rready` is low.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
  // Word indices (byte offset / 4) of the fixed registers
  localparam int W_CTRL = 0;
  localparam int W_GIE  = 1;
  localparam int W_IER  = 2;
  localparam int W_ISR  = 3;
  localparam int W_ARGS = 4;

  // Control word bit positions
  localparam int B_START = 0;
  localparam int B_DONE  = 1;
  localparam int B_IDLE  = 2;
  localparam int B_READY = 3;
  localparam int B_AUTO  = 7;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Word index of word w of argument a; one reserved word follows each argument
  function automatic int arg_word(input int a, input int w, input int wpa);
    return W_ARGS + a * (wpa + 1) + w;
  endfunction
endpackage

// File: rtl/axil_wr_capture.sv
module axil_wr_capture #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic aw_full, w_full, b_q;

  assign awready = ~aw_full;
  assign wready  = ~w_full;
  assign bvalid  = b_q;
  assign wr_en   = aw_full & w_full & ~b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      b_q     <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      if (awvalid && !aw_full) begin
        aw_full <= 1'b1;
        wr_addr <= awaddr;
      end
      if (wvalid && !w_full) begin
        w_full  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end
      if (wr_en) begin
        aw_full <= 1'b0;
        w_full  <= 1'b0;
        b_q     <= 1'b1;
      end else if (b_q && bready) begin
        b_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_value
);
  logic r_q;

  assign arready = ~r_q;
  assign rvalid  = r_q;
  assign rd_en   = arvalid & ~r_q;
  assign rd_addr = araddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q   <= 1'b0;
      rdata <= '0;
    end else if (rd_en) begin
      r_q   <= 1'b1;
      rdata <= rd_value;
    end else if (r_q && rready) begin
      r_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_status_core.sv
module ctrl_status_core
  import accel_ctrl_pkg::*;
#(
  parameter int WA_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_word,
  input  logic [7:0]      wr_byte0,
  input  logic            wr_strb0,
  input  logic            rd_ctrl,
  input  logic            core_done,
  input  logic            core_ready,
  output logic            start_q,
  output logic            done_q,
  output logic            auto_q,
  output logic            gie_q,
  output logic [1:0]      ier_q,
  output logic [1:0]      isr_q,
  output logic            irq
);
  logic wr_b0;
  logic hit_ctrl, hit_gie, hit_ier, hit_isr;
  logic [1:0] isr_set, isr_tog;

  assign wr_b0    = wr_en & wr_strb0;
  assign hit_ctrl = wr_b0 && (int'(wr_word) == W_CTRL);
  assign hit_gie  = wr_b0 && (int'(wr_word) == W_GIE);
  assign hit_ier  = wr_b0 && (int'(wr_word) == W_IER);
  assign hit_isr  = wr_b0 && (int'(wr_word) == W_ISR);
  assign isr_set  = {core_ready & ier_q[1], core_done & ier_q[0]};
  assign isr_tog  = hit_isr ? wr_byte0[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      auto_q  <= 1'b0;
      gie_q   <= 1'b0;
      ier_q   <= 2'b00;
      isr_q   <= 2'b00;
      irq     <= 1'b0;
    end else begin
      if (hit_ctrl && wr_byte0[B_START])      start_q <= 1'b1;
      else if (core_done && auto_q)           start_q <= 1'b1;
      else if (start_q && core_ready)         start_q <= 1'b0;

      if (core_done)    done_q <= 1'b1;
      else if (rd_ctrl) done_q <= 1'b0;

      if (hit_ctrl) auto_q <= wr_byte0[B_AUTO];
      if (hit_gie)  gie_q  <= wr_byte0[0];
      if (hit_ier)  ier_q  <= wr_byte0[1:0];

      isr_q <= (isr_q ^ isr_tog) | isr_set;
      irq   <= gie_q & |(ier_q & isr_q);
    end
  end
endmodule

// File: rtl/arg_bank.sv
module arg_bank
  import accel_ctrl_pkg::*;
#(
  parameter int NUM_ARGS = 2,
  parameter int ARG_W    = 64,
  parameter int DATA_W   = 32,
  parameter int WA_W     = 4,
  localparam int WPA    = ARG_W / DATA_W,
  localparam int NB     = DATA_W / 8,
  localparam int NWORDS = NUM_ARGS * WPA
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [WA_W-1:0]           wr_word,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [NB-1:0]             wr_strb,
  input  logic [WA_W-1:0]           rd_word,
  output logic [DATA_W-1:0]         rd_val,
  output logic [NUM_ARGS*ARG_W-1:0] args
);
  logic [DATA_W-1:0] hit_val [NWORDS];

  for (genvar a = 0; a < NUM_ARGS; a++) begin : g_arg
    for (genvar w = 0; w < WPA; w++) begin : g_word
      localparam int IDX = arg_word(a, w, WPA);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (wr_en && int'(wr_word) == IDX) begin
          for (int b = 0; b < NB; b++)
            if (wr_strb[b]) q[8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
      assign args[a*ARG_W + w*DATA_W +: DATA_W] = q;
      assign hit_val[a*WPA + w] = (int'(rd_word) == IDX) ? q : '0;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NWORDS; i++) rd_val = rd_val | hit_val[i];
  end
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int NUM_ARGS = 2,
  parameter int ARG_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  localparam int STRB_W = DATA_W / 8,
  localparam int WA_W   = ADDR_W - 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         s_awaddr,
  input  logic                      s_awvalid,
  output logic                      s_awready,
  input  logic [DATA_W-1:0]         s_wdata,
  input  logic [STRB_W-1:0]         s_wstrb,
  input  logic                      s_wvalid,
  output logic                      s_wready,
  output logic [1:0]                s_bresp,
  output logic                      s_bvalid,
  input  logic                      s_bready,
  input  logic [ADDR_W-1:0]         s_araddr,
  input  logic                      s_arvalid,
  output logic                      s_arready,
  output logic [DATA_W-1:0]         s_rdata,
  output logic [1:0]                s_rresp,
  output logic                      s_rvalid,
  input  logic                      s_rready,
  output logic                      core_start,
  input  logic                      core_done,
  input  logic                      core_idle,
  input  logic                      core_ready,
  output logic [NUM_ARGS*ARG_W-1:0] core_args,
  output logic                      irq
);
  logic              wr_en, rd_en, rd_ctrl;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_value, arg_rd;
  logic [STRB_W-1:0] wr_strb;
  logic [WA_W-1:0]   wr_word, rd_word;
  logic              done_q, auto_q, gie_q;
  logic [1:0]        ier_q, isr_q;

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;
  assign wr_word = wr_addr[ADDR_W-1:2];
  assign rd_word = rd_addr[ADDR_W-1:2];
  assign rd_ctrl = rd_en && (int'(rd_word) == W_CTRL);

  axil_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  axil_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_value(rd_value)
  );

  ctrl_status_core #(.WA_W(WA_W)) u_core (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_word(wr_word), .wr_byte0(wr_data[7:0]), .wr_strb0(wr_strb[0]),
    .rd_ctrl(rd_ctrl), .core_done(core_done), .core_ready(core_ready),
    .start_q(core_start), .done_q(done_q), .auto_q(auto_q),
    .gie_q(gie_q), .ier_q(ier_q), .isr_q(isr_q), .irq(irq)
  );

  arg_bank #(.NUM_ARGS(NUM_ARGS), .ARG_W(ARG_W), .DATA_W(DATA_W), .WA_W(WA_W)) u_args (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_word(rd_word), .rd_val(arg_rd), .args(core_args)
  );

  always_comb begin
    rd_value = '0;
    case (int'(rd_word))
      W_CTRL: begin
        rd_value[B_START] = core_start;
        rd_value[B_DONE]  = done_q;
        rd_value[B_IDLE]  = core_idle;
        rd_value[B_READY] = core_ready;
        rd_value[B_AUTO]  = auto_q;
      end
      W_GIE:   rd_value[0]   = gie_q;
      W_IER:   rd_value[1:0] = ier_q;
      W_ISR:   rd_value[1:0] = isr_q;
      default: rd_value      = arg_rd;
    endcase
  end
endmodule

// File: rtl/accel_ctrl_regs_chk.sv
module accel_ctrl_regs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic              s_arready,
  input logic [DATA_W-1:0] s_rdata,
  input logic              core_start,
  input logic              core_ready,
  input logic              core_done,
  input logic              irq,
  input logic              wr_en,
  input logic              rd_ctrl,
  input logic              done_q,
  input logic [1:0]        isr_q
);
  // R2: a pending write response is held until accepted
  a_r2_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid);

  // R13: read data stays valid and stable until accepted, and no new address is taken
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && !s_arready);

  // R4: start drops after the core accepts it when nothing sets it again
  a_r4_start_clear: assert property (@(posedge clk) disable iff (rst)
    core_start && core_ready && !core_done && !wr_en |=> !core_start);

  // R5: done stays set until a control read
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_q && !rd_ctrl |=> done_q);

  // R9: status changes only on a write or a core pulse
  a_r9_isr_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !core_done && !core_ready |=> $stable(isr_q));

  // R10: an interrupt needs a pending status bit one cycle earlier
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|isr_q));
endmodule

bind accel_ctrl_regs accel_ctrl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_arready(s_arready), .s_rdata(s_rdata),
  .core_start(core_start), .core_ready(core_ready), .core_done(core_done), .irq(irq),
  .wr_en(wr_en), .rd_ctrl(rd_ctrl), .done_q(done_q), .isr_q(isr_q)
);

// File: tb/accel_ctrl_regs_bench.sv
`timescale 1ns/1ps
module accel_ctrl_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        core_done = 0, core_idle = 0, core_ready = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, core_start, irq;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [127:0] core_args;

  always #4 clk = ~clk;

  accel_ctrl_regs u_accel_ctrl_regs (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
    .core_ready(core_ready), .core_args(core_args), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_awf, m_wf, m_b, m_r;
  int m_wa;
  bit [31:0] m_wd, m_rdata;
  bit [3:0]  m_ws;
  bit m_start, m_done, m_auto, m_gie, m_irq;
  bit [1:0] m_ier, m_isr;
  bit [31:0] m_arg [4];

  function automatic int arg_slot(input int word);
    // words 4,5 -> arg0; 7,8 -> arg1; else -1
    if (word == 4) return 0;
    if (word == 5) return 1;
    if (word == 7) return 2;
    if (word == 8) return 3;
    return -1;
  endfunction

  function automatic bit [31:0] model_read(input int word);
    bit [31:0] v = 0;
    case (word)
      0: v = {24'd0, m_auto, 3'd0, core_ready, core_idle, m_done, m_start};
      1: v = {31'd0, m_gie};
      2: v = {30'd0, m_ier};
      3: v = {30'd0, m_isr};
      default: if (arg_slot(word) >= 0) v = m_arg[arg_slot(word)];
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_awf = 0; m_wf = 0; m_b = 0; m_r = 0; m_rdata = 0;
      m_start = 0; m_done = 0; m_auto = 0; m_gie = 0; m_irq = 0;
      m_ier = 0; m_isr = 0;
      for (int i = 0; i < 4; i++) m_arg[i] = 0;
    end else begin
      bit fire, rd, n_start, n_done, n_auto, n_gie, n_irq, n_awf, n_wf, n_b, n_r;
      bit [1:0] n_ier, n_isr, tog;
      bit [31:0] n_rdata;
      int rword;
      fire = m_awf && m_wf && !m_b;
      rd = s_arvalid && !m_r;
      rword = int'(s_araddr[5:2]);
      n_rdata = rd ? model_read(rword) : m_rdata;
      n_r = rd ? 1 : ((m_r && s_rready) ? 0 : m_r);
      n_awf = fire ? 0 : (m_awf || s_awvalid);
      n_wf  = fire ? 0 : (m_wf || s_wvalid);
      if (s_awvalid && !m_awf) m_wa = int'(s_awaddr[5:2]);
      n_b = fire ? 1 : ((m_b && s_bready) ? 0 : m_b);
      n_irq = m_gie && ((m_ier[0] && m_isr[0]) || (m_ier[1] && m_isr[1]));
      n_auto = m_auto; n_gie = m_gie; n_ier = m_ier; tog = 0;
      n_start = m_start;
      if (fire && m_ws[0] && m_wa == 0 && m_wd[0]) n_start = 1;
      else if (core_done && m_auto) n_start = 1;
      else if (m_start && core_ready) n_start = 0;
      n_done = core_done ? 1 : ((rd && rword == 0) ? 0 : m_done);
      if (fire && m_ws[0]) begin
        if (m_wa == 0) n_auto = m_wd[7];
        if (m_wa == 1) n_gie = m_wd[0];
        if (m_wa == 2) n_ier = m_wd[1:0];
        if (m_wa == 3) tog = m_wd[1:0];
      end
      if (fire && arg_slot(m_wa) >= 0)
        for (int b = 0; b < 4; b++)
          if (m_ws[b]) m_arg[arg_slot(m_wa)][8*b +: 8] = m_wd[8*b +: 8];
      n_isr = (m_isr ^ tog) | {core_ready && m_ier[1], core_done && m_ier[0]};
      if (s_wvalid && !m_wf) begin m_wd = s_wdata; m_ws = s_wstrb; end
      m_awf = n_awf; m_wf = n_wf; m_b = n_b; m_r = n_r; m_rdata = n_rdata;
      m_start = n_start; m_done = n_done; m_auto = n_auto; m_gie = n_gie;
      m_ier = n_ier; m_isr = n_isr; m_irq = n_irq;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 awready", s_awready, !m_awf);
      chk("R2 wready", s_wready, !m_wf);
      chk("R2 bvalid", s_bvalid, m_b);
      chk("R13 rvalid", s_rvalid, m_r);
      chk("R13 arready", s_arready, !m_r);
      if (m_r) chk("R13 rdata", s_rdata, m_rdata);
      chk("R4 core_start", core_start, m_start);
      chk("R10 irq", irq, m_irq);
      chk("R11 core_args", core_args, {m_arg[3], m_arg[2], m_arg[1], m_arg[0]});
    end
  end

  // ---------------- stimulus tasks ----------------
  // order: 0 together, 1 address first, 2 data first
  task automatic axi_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    @(negedge clk);
    if (order != 2) begin s_awaddr = a; s_awvalid = 1; end
    if (order != 1) begin s_wdata = d; s_wstrb = s; s_wvalid = 1; end
    if (order != 0) begin
      repeat (2) begin
        @(negedge clk);
        if (s_awvalid && !s_awready) s_awvalid = s_awvalid;
      end
      s_awvalid = 0; s_wvalid = 0;
      if (order == 1) begin s_wdata = d; s_wstrb = s; s_wvalid = 1; end
      else begin s_awaddr = a; s_awvalid = 1; end
    end
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    while (!s_bvalid) @(negedge clk);
    chk("R2 bresp", s_bresp, 2'b00);
    @(negedge clk);
  endtask

  task automatic axi_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    chk("R12 rresp", s_rresp, 2'b00);
    @(negedge clk);
  endtask

  task automatic pulse(input bit is_done);
    @(negedge clk);
    if (is_done) core_done = 1; else core_ready = 1;
    @(negedge clk);
    core_done = 0; core_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 start", core_start, 0);
    chk("R1 irq", irq, 0);
    chk("R1 readies", {s_awready, s_wready, s_arready, s_bvalid, s_rvalid}, 5'b11100);
    chk("R1 args", core_args, 0);
    axi_read(6'h00, rv); chk("R1 ctrl", rv, 0);
    axi_read(6'h0c, rv); chk("R1 isr", rv, 0);

    // R2 / R11: three orderings
    axi_write(6'h10, 32'h11223344, 4'hF, 0);
    axi_write(6'h14, 32'h55667788, 4'hF, 1);
    axi_write(6'h1c, 32'h99AABBCC, 4'hF, 2);
    axi_write(6'h20, 32'hDDEEFF00, 4'hF, 0);
    chk("R11 arg0", core_args[63:0], 64'h55667788_11223344);
    chk("R11 arg1", core_args[127:64], 64'hDDEEFF00_99AABBCC);
    axi_read(6'h20, rv); chk("R11 read hi1", rv, 32'hDDEEFF00);

    // R3 byte strobes
    axi_write(6'h10, 32'hAABBCCDD, 4'b0101, 1);
    axi_read(6'h10, rv); chk("R3 strobe", rv, 32'h11BB33DD);
    axi_write(6'h04, 32'h1, 4'b0010, 0);
    axi_read(6'h04, rv); chk("R3 no byte0", rv, 0);

    // R12 reserved words
    axi_write(6'h18, 32'hFFFFFFFF, 4'hF, 0);
    axi_write(6'h24, 32'hFFFFFFFF, 4'hF, 2);
    axi_read(6'h18, rv); chk("R12 rsv18", rv, 0);
    axi_read(6'h24, rv); chk("R12 rsv24", rv, 0);
    axi_read(6'h3c, rv); chk("R12 unmapped", rv, 0);
    chk("R12 args kept", core_args, {64'hDDEEFF00_99AABBCC, 64'h55667788_11BB33DD});

    // R8 enables
    axi_write(6'h04, 32'h1, 4'h1, 0);
    axi_write(6'h08, 32'h3, 4'h1, 0);
    axi_read(6'h04, rv); chk("R8 gie", rv, 1);
    axi_read(6'h08, rv); chk("R8 ier", rv, 3);

    // R4 start / handshake clear
    axi_write(6'h00, 32'h1, 4'h1, 0);
    chk("R4 start set", core_start, 1);
    axi_write(6'h00, 32'h0, 4'h1, 0);
    chk("R4 zero no effect", core_start, 1);
    pulse(0);
    chk("R4 start cleared", core_start, 0);
    axi_read(6'h0c, rv); chk("R9 ready status", rv, 2);
    chk("R10 irq on ready", irq, 1);

    // R5 done sticky, cleared by read, R6 idle/ready bits
    core_idle = 1;
    pulse(1);
    repeat (3) @(negedge clk);
    axi_read(6'h00, rv); chk("R5 done set / R6 idle", rv, 32'h6);
    axi_read(6'h00, rv); chk("R5 done cleared", rv, 32'h4);
    axi_read(6'h0c, rv); chk("R9 both status", rv, 3);

    // R5 collision: done pulse in the accept cycle of a control read
    @(negedge clk);
    s_araddr = 6'h00; s_arvalid = 1; core_done = 1;
    @(negedge clk);
    s_arvalid = 0; core_done = 0;
    @(negedge clk);
    axi_read(6'h00, rv); chk("R5 collision keeps done", rv[1], 1);

    // R9 toggle on write, R10 irq falls
    axi_write(6'h0c, 32'h3, 4'h1, 0);
    axi_read(6'h0c, rv); chk("R9 toggle clear", rv, 0);
    @(negedge clk);
    chk("R10 irq low", irq, 0);
    axi_write(6'h0c, 32'h1, 4'h1, 2);
    axi_read(6'h0c, rv); chk("R9 toggle set", rv, 1);
    axi_write(6'h08, 32'h2, 4'h1, 0);
    @(negedge clk);
    chk("R10 masked", irq, 0);

    // R7 auto restart, R6 auto bit readback and ready bit
    axi_write(6'h00, 32'h81, 4'h1, 0);
    pulse(0);
    chk("R7 start cleared", core_start, 0);
    pulse(1);
    chk("R7 relaunch", core_start, 1);
    core_ready = 1;
    @(negedge clk);
    s_araddr = 6'h00; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0; core_ready = 0;
    chk("R6 ctrl word", s_rdata, 32'h8E);
    @(negedge clk);

    // R13 hold while rready low
    s_rready = 0;
    @(negedge clk);
    s_araddr = 6'h14; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0;
    repeat (3) @(negedge clk);
    chk("R13 held", {s_rvalid, s_rdata}, {1'b1, 32'h55667788});
    s_rready = 1;
    @(negedge clk);
    chk("R13 released", s_rvalid, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule